// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a small table that remembers where recently taken branches went. The fetch stage looks it up with the pc it is fetching. The lookup is combinational, so it completes in the same cycle as the instruction memory read. A hit means that the instruction at that pc was a taken branch the last time it resolved. The returned target then becomes the next fetch address. On a miss, fetch goes on to pc + 4.

The execute stage drives a single update port, and the update commits at the clock edge that ends the cycle. After a not-taken branch that was predicted taken, the execute stage invalidates the entry. After a taken branch that was predicted not-taken, it installs the pc and target pair. The table is direct-mapped with 2^IDX_BITS entries. The word-address bits just above the byte offset select the slot, and every pc bit above those is kept as the tag. A new install simply replaces whatever occupied its slot.

Top module: `btb_top`

## Requirements
- R1: While rstN is low and after it is released, every entry is invalid, so every lookup misses until an install occurs.
- R2: lookupHit is 1 only when the slot selected by lookupPc[IDX_BITS+1:2] is valid and its stored tag equals lookupPc[31:IDX_BITS+2]. lookupTarget then equals the target installed with that pc.
- R3: On a miss, lookupTarget is 0.
- R4: An install (updValid=1, updInstall=1) writes updPc's tag and updTarget into its slot at the rising clock edge. A lookup of that pc hits from the next cycle.
- R5: An install to an occupied slot replaces the old occupant. A lookup of the old pc then misses, because its tag no longer matches.
- R6: An invalidate (updValid=1, updInstall=0) clears the valid bit of the slot selected by updPc, whatever tag that slot holds. Other slots are unchanged.
- R7: With updValid=0, no entry changes, whatever updInstall, updPc and updTarget carry.
- R8: lookupPc[1:0] and updPc[1:0] take no part in the index or the tag.
- R9: A lookup in the same cycle as an update to the same slot returns the contents from before the update.
- R10: With IDX_BITS=0 the table has a single entry, and its tag is pc[31:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupPc | input | 32 | Fetch pc being looked up |
| lookupHit | output | 1 | Predicted taken: valid slot with matching tag |
| lookupTarget | output | 32 | Predicted next pc on hit, 0 on miss |
| updValid | input | 1 | Update request from execute this cycle |
| updInstall | input | 1 | 1 = install pair, 0 = invalidate slot |
| updPc | input | 32 | pc of the resolved branch |
| updTarget | input | 32 | Taken target, used on install |

## Verification
The bench targets aliasing in both directions. Two pcs that share a slot but differ in tag must not hit for each other, whether they differ in the lowest tag bit or the highest. A design that indexed with too many bits, or kept a short tag, would report false hits there. An invalidate issued with a foreign tag must still clear the slot; a design that compared tags on invalidate would leave a stale prediction. The bench checks a same-cycle update and lookup before the edge to catch write-through forwarding. It drives pcs with nonzero low bits to catch an index taken from the wrong place. A single-entry instance exercises the degenerate index width.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Write strobes passed from control to datapath
  typedef struct packed {
    logic wrEn;      // an update commits at this edge
    logic setValid;  // 1: install pair, 0: clear valid bit
  } btbStrobe_t;
endpackage

// File: rtl/btb_control.sv
module btb_control (
  input  logic               updValid,
  input  logic               updInstall,
  output btb_pkg::btbStrobe_t strobe
);
  always_comb begin
    strobe.wrEn     = updValid;
    strobe.setValid = updValid & updInstall;
  end
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath #(
  parameter int IDX_BITS = 4,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  btb_pkg::btbStrobe_t strobe,
  input  logic [ADDR_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0]   updPc,
  input  logic [ADDR_W-1:0]   updTarget,
  output logic                lookupHit,
  output logic [ADDR_W-1:0]   lookupTarget
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int IDX_W   = (IDX_BITS == 0) ? 1 : IDX_BITS;
  localparam int TAG_LSB = IDX_BITS + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic [IDX_W-1:0]  lkIdx;
  logic [IDX_W-1:0]  upIdx;
  logic [TAG_W-1:0]  lkTag;
  logic [TAG_W-1:0]  upTag;
  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]  tagQ    [ENTRIES];
  logic [ADDR_W-1:0] targetQ [ENTRIES];
  logic              padUnused;

  assign lkTag     = lookupPc[ADDR_W-1:TAG_LSB];
  assign upTag     = updPc[ADDR_W-1:TAG_LSB];
  assign padUnused = ^{lookupPc[1:0], updPc[1:0]};

  generate
    if (IDX_BITS == 0) begin : g_single
      assign lkIdx = '0;
      assign upIdx = '0;
    end else begin : g_multi
      assign lkIdx = lookupPc[TAG_LSB-1:2];
      assign upIdx = updPc[TAG_LSB-1:2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else if (strobe.wrEn) validQ[upIdx] <= strobe.setValid;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && strobe.setValid) begin
      tagQ[upIdx]    <= upTag;
      targetQ[upIdx] <= updTarget;
    end
  end

  logic slotHit;
  always_comb begin
    slotHit      = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    lookupHit    = slotHit;
    lookupTarget = slotHit ? targetQ[lkIdx] : '0;
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(validQ));
  // R4
  install_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.setValid) |=> validQ[$past(upIdx)]);
  // R6
  invalidate_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.setValid) |=> !validQ[$past(upIdx)]);
  // R6
  single_slot_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ ^ $past(validQ)) <= 1);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (validQ == '0));
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int IDX_BITS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] lookupPc,
  output logic        lookupHit,
  output logic [31:0] lookupTarget,
  input  logic        updValid,
  input  logic        updInstall,
  input  logic [31:0] updPc,
  input  logic [31:0] updTarget
);
  btb_pkg::btbStrobe_t strobe;

  btb_control u_ctrl (
    .updValid  (updValid),
    .updInstall(updInstall),
    .strobe    (strobe)
  );

  btb_datapath #(.IDX_BITS(IDX_BITS), .ADDR_W(32)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupPc    (lookupPc),
    .updPc       (updPc),
    .updTarget   (updTarget),
    .lookupHit   (lookupHit),
    .lookupTarget(lookupTarget)
  );
endmodule

// File: tb/tb_btb_top.sv
module tb_btb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 install, 2 invalidate, 3 install fields with updValid low
    logic [31:0] uPc;
    logic [31:0] uTgt;
    logic [31:0] lPc;
    logic        eHit;
    logic [31:0] eTgt;
  } vec_t;

  // IDX_BITS=4: slot = pc[5:2], tag = pc[31:6]
  localparam vec_t VEC [14] = '{
    '{2'd1, 32'h100,       32'h200, 32'h100,       1'b1, 32'h200}, // R4 R2
    '{2'd0, 32'h0,         32'h0,   32'h104,       1'b0, 32'h0},   // R3
    '{2'd1, 32'h140,       32'h300, 32'h100,       1'b0, 32'h0},   // R5
    '{2'd0, 32'h0,         32'h0,   32'h140,       1'b1, 32'h300}, // R5
    '{2'd1, 32'h108,       32'h40,  32'h108,       1'b1, 32'h40},  // R4
    '{2'd2, 32'h108,       32'h0,   32'h108,       1'b0, 32'h0},   // R6
    '{2'd0, 32'h0,         32'h0,   32'h140,       1'b1, 32'h300}, // R6 other slot
    '{2'd2, 32'h180,       32'h0,   32'h140,       1'b0, 32'h0},   // R6 foreign tag
    '{2'd1, 32'h3C,        32'hABC, 32'h3C,        1'b1, 32'hABC}, // R4
    '{2'd3, 32'h3C,        32'h111, 32'h3C,        1'b1, 32'hABC}, // R7
    '{2'd0, 32'h0,         32'h0,   32'h7C,        1'b0, 32'h0},   // R2 alias
    '{2'd0, 32'h0,         32'h0,   32'h3E,        1'b1, 32'hABC}, // R8
    '{2'd1, 32'h80000012,  32'h20,  32'h10,        1'b0, 32'h0},   // R2 top tag bit, R8
    '{2'd0, 32'h0,         32'h0,   32'h80000010,  1'b1, 32'h20}   // R2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] lookupPc = '0, updPc = '0, updTarget = '0;
  logic updValid = 1'b0, updInstall = 1'b0;
  logic lookupHit;
  logic [31:0] lookupTarget;
  logic [31:0] oneLookupPc = '0, oneUpdPc = '0, oneUpdTarget = '0;
  logic oneUpdValid = 1'b0;
  logic oneHit;
  logic [31:0] oneTarget;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_top #(.IDX_BITS(4)) dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .lookupHit(lookupHit),
    .lookupTarget(lookupTarget), .updValid(updValid), .updInstall(updInstall),
    .updPc(updPc), .updTarget(updTarget));

  btb_top #(.IDX_BITS(0)) dutOne (
    .clk(clk), .rstN(rstN), .lookupPc(oneLookupPc), .lookupHit(oneHit),
    .lookupTarget(oneTarget), .updValid(oneUpdValid), .updInstall(1'b1),
    .updPc(oneUpdPc), .updTarget(oneUpdTarget));

  task automatic check(input string req, input logic hit, input logic [31:0] tgt,
                       input logic eHit, input logic [31:0] eTgt);
    checks++;
    if (hit !== eHit || tgt !== eTgt) begin
      fails++;
      $display("FAIL %s: actual hit=%0b target=%h expected hit=%0b target=%h",
               req, hit, tgt, eHit, eTgt);
    end
  endtask

  // drive at negedge, commit at posedge, sample at the following negedge
  task automatic step(input logic [1:0] op, input logic [31:0] uPc,
                      input logic [31:0] uTgt, input logic [31:0] lPc);
    @(negedge clk);
    updValid   = (op == 2'd1) || (op == 2'd2);
    updInstall = (op == 2'd1) || (op == 2'd3);
    updPc      = uPc;
    updTarget  = uTgt;
    lookupPc   = lPc;
    @(posedge clk);
    #1 updValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic stepOne(input logic wr, input logic [31:0] uPc,
                         input logic [31:0] uTgt, input logic [31:0] lPc);
    @(negedge clk);
    oneUpdValid = wr; oneUpdPc = uPc; oneUpdTarget = uTgt; oneLookupPc = lPc;
    @(posedge clk);
    #1 oneUpdValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 during and after reset
    lookupPc = 32'h100;
    #(CLK_PERIOD * 2 + 2);
    check("R1 in reset", lookupHit, lookupTarget, 1'b0, 32'h0);
    @(negedge clk) rstN = 1'b1;
    step(2'd0, 32'h0, 32'h0, 32'h3C);
    check("R1 after reset", lookupHit, lookupTarget, 1'b0, 32'h0);

    foreach (VEC[i]) begin
      step(VEC[i].op, VEC[i].uPc, VEC[i].uTgt, VEC[i].lPc);
      check($sformatf("vector %0d (R2..R8)", i), lookupHit, lookupTarget,
            VEC[i].eHit, VEC[i].eTgt);
    end

    // R9: same-cycle install to slot 15 shows old contents, new after the edge
    @(negedge clk);
    updValid = 1'b1; updInstall = 1'b1; updPc = 32'h3C; updTarget = 32'h555;
    lookupPc = 32'h3C;
    #1 check("R9 before edge", lookupHit, lookupTarget, 1'b1, 32'hABC);
    @(posedge clk);
    #1 updValid = 1'b0;
    @(negedge clk);
    check("R9 after edge", lookupHit, lookupTarget, 1'b1, 32'h555);

    // R10 single-entry instance
    stepOne(1'b1, 32'h100, 32'h10, 32'h100);
    check("R10 hit", oneHit, oneTarget, 1'b1, 32'h10);
    stepOne(1'b0, 32'h0, 32'h0, 32'h104);
    check("R10 tag pc[31:2]", oneHit, oneTarget, 1'b0, 32'h0);
    stepOne(1'b1, 32'h104, 32'h20, 32'h100);
    check("R10 overwrite", oneHit, oneTarget, 1'b0, 32'h0);

    // R1 reset mid-run clears installed entries
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    step(2'd0, 32'h0, 32'h0, 32'h3C);
    check("R1 re-reset", lookupHit, lookupTarget, 1'b0, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule